// File: doc/BRIEF.md
# Bit-Sliced Pipelined Adder Tree

This block adds `N_IN` unsigned operands of `SLICE_W*SLICES` bits each and returns their exact sum. A balanced binary tree of `N_IN-1` two-input adders does the work. Each adder is not a single wide carry chain. It is cut into `SLICES` slices of `SLICE_W` bits, and each slice adds in its own register stage. The carry out of each slice is registered and feeds the next slice one cycle later, so no combinational carry path in the tree is longer than one slice. The top slice also absorbs the growth bits.

To make that slicing line up in time, the lower slices of each operand enter earlier than the higher ones. On entry, slice `i` of every operand is held back `i` cycles. The whole tree then works in that staggered timing. At the root, delay lines realign the result slices so that a complete sum word appears in one cycle.

A full new operand set can be accepted on every clock. A valid strobe follows the data through a matching delay. The block is meant for wide accumulation datapaths where clock rate matters more than a few cycles of latency.

Top module: `bsat_tree`

## Requirements
- R1: `sum_out` is the exact sum of all `N_IN` operands, `SLICE_W*SLICES + log2(N_IN)` bits wide (11 bits at the defaults), and never wraps: four operands of 511 give 2044.
- R2: Operands sampled at a rising edge appear on `sum_out` right after the LAT-th rising edge, counting the sampling edge as the first, where LAT = log2(N_IN) + SLICES - 1 (4 at the defaults). Before that, `out_valid` stays low.
- R3: A new operand set is taken on every clock with no idle cycles. The sum path advances every cycle whether `in_valid` is high or low, so back-to-back sets give back-to-back results, each LAT cycles after its inputs.
- R4: `out_valid` equals `in_valid` delayed by exactly LAT cycles, including any gaps in the valid pattern.
- R5: A synchronous active-high `rst` clears `out_valid` and `sum_out` to zero at the next rising edge, whether idle or in mid-stream.
- R6: Carries cross every slice boundary correctly, including a ripple through all slices (511 + 1 = 512; 7 + 1 = 8; 63 + 1 = 64 with 3-bit slices).
- R7: Operand `i` occupies `in_data[i*W +: W]`, where W = `SLICE_W*SLICES`. Every position carries equal weight, so one nonzero operand in the top position or in the bottom position alone gives that operand's value.
- R8: Each result word is coherent: all its slices come from the same operand set, even when neighbouring sets differ in every slice (all-max, all-zero, all-max in consecutive cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operand set on `in_data` as meaningful |
| in_data | input | N_IN*SLICE_W*SLICES | Packed operands, operand `i` at `[i*W +: W]` |
| out_valid | output | 1 | `in_valid` delayed by the pipeline latency |
| sum_out | output | SLICE_W*SLICES+log2(N_IN) | Full-precision sum, aligned with `out_valid` |

## Verification
The assertions assume that `in_valid` and `in_data` hold known values on every edge after reset. The zero-flush property further assumes that the datapath depends only on operands captured in the last LAT cycles. The no-wrap property needs no assumption about operand values, because the port width already limits every operand to W bits. The stimulus drives defined values from time zero, holds reset over the first edges, and changes inputs only on falling edges. Its operands run from zero to the all-ones maximum, so every property is exercised within its assumptions.

// File: rtl/bsat_pkg.sv
package bsat_pkg;

    // Lowest bit of slice idx within a sliced word.
    function automatic int slice_lsb(input int idx, input int sw);
        return idx * sw;
    endfunction

    // The top slice also carries the growth bits of the tree.
    function automatic int slice_width(input int idx, input int nslices, input int sw, input int ext);
        return (idx == nslices - 1) ? sw + ext : sw;
    endfunction

    // Input skew, one register per tree level, output deskew.
    function automatic int pipe_latency(input int nops, input int nslices);
        return $clog2(nops) + nslices - 1;
    endfunction

endpackage

// File: rtl/bsat_delay.sv
module bsat_delay #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) stage_q[j] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int j = 1; j < DEPTH; j++) stage_q[j] <= stage_q[j-1];
        end
    end

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/bsat_skew.sv
module bsat_skew
    import bsat_pkg::*;
#(
    parameter int SLICE_W = 3,
    parameter int SLICES  = 3,
    parameter int EXT_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [SLICE_W*SLICES-1:0]         op_in,
    output logic [SLICE_W*SLICES+EXT_W-1:0]   op_skewed
);
    localparam int OP_W = SLICE_W * SLICES;

    wire [OP_W+EXT_W-1:0] skew_w;

    generate
        for (genvar i = 0; i < SLICES; i++) begin : g_slice
            localparam int LSB = slice_lsb(i, SLICE_W);
            if (i == 0) begin : g_direct
                assign skew_w[LSB +: SLICE_W] = op_in[LSB +: SLICE_W];
            end else begin : g_delayed
                bsat_delay #(.WIDTH(SLICE_W), .DEPTH(i)) u_dly (
                    .clk (clk),
                    .rst (rst),
                    .d   (op_in[LSB +: SLICE_W]),
                    .q   (skew_w[LSB +: SLICE_W])
                );
            end
        end
    endgenerate

    // Growth bits start empty; they ride with the top slice.
    assign skew_w[OP_W +: EXT_W] = '0;
    assign op_skewed = skew_w;
endmodule

// File: rtl/bsat_node.sv
module bsat_node
    import bsat_pkg::*;
#(
    parameter int SLICE_W = 3,
    parameter int SLICES  = 3,
    parameter int EXT_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [SLICE_W*SLICES+EXT_W-1:0] opa,
    input  logic [SLICE_W*SLICES+EXT_W-1:0] opb,
    output logic [SLICE_W*SLICES+EXT_W-1:0] sum_q
);
    localparam int RW = SLICE_W * SLICES + EXT_W;

    wire [SLICES:0] carry_w;
    wire [RW-1:0]   sum_w;

    assign carry_w[0] = 1'b0;

    generate
        for (genvar i = 0; i < SLICES; i++) begin : g_slice
            localparam int LSB = slice_lsb(i, SLICE_W);
            localparam int WI  = slice_width(i, SLICES, SLICE_W, EXT_W);

            logic [WI:0]   total;
            logic [WI-1:0] part_q;

            assign total = {1'b0, opa[LSB +: WI]} + {1'b0, opb[LSB +: WI]}
                         + {{WI{1'b0}}, carry_w[i]};

            always_ff @(posedge clk) begin
                if (rst) part_q <= '0;
                else     part_q <= total[WI-1:0];
            end
            assign sum_w[LSB +: WI] = part_q;

            if (i < SLICES - 1) begin : g_mid
                logic carry_q;
                always_ff @(posedge clk) begin
                    if (rst) carry_q <= 1'b0;
                    else     carry_q <= total[WI];
                end
                assign carry_w[i+1] = carry_q;
            end else begin : g_top
                assign carry_w[i+1] = total[WI];
            end
        end
    endgenerate

    assign sum_q = sum_w;

    // R1: the widened top slice must never overflow.
    assert_no_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        !carry_w[SLICES])
        else $error("top slice overflow in adder node");
endmodule

// File: rtl/bsat_deskew.sv
module bsat_deskew
    import bsat_pkg::*;
#(
    parameter int SLICE_W = 3,
    parameter int SLICES  = 3,
    parameter int EXT_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [SLICE_W*SLICES+EXT_W-1:0] skewed_in,
    output logic [SLICE_W*SLICES+EXT_W-1:0] aligned_out
);
    localparam int RW = SLICE_W * SLICES + EXT_W;

    wire [RW-1:0] align_w;

    generate
        for (genvar i = 0; i < SLICES; i++) begin : g_slice
            localparam int LSB = slice_lsb(i, SLICE_W);
            localparam int WI  = slice_width(i, SLICES, SLICE_W, EXT_W);
            localparam int DLY = SLICES - 1 - i;
            if (DLY == 0) begin : g_direct
                assign align_w[LSB +: WI] = skewed_in[LSB +: WI];
            end else begin : g_delayed
                bsat_delay #(.WIDTH(WI), .DEPTH(DLY)) u_dly (
                    .clk (clk),
                    .rst (rst),
                    .d   (skewed_in[LSB +: WI]),
                    .q   (align_w[LSB +: WI])
                );
            end
        end
    endgenerate

    assign aligned_out = align_w;
endmodule

// File: rtl/bsat_tree.sv
module bsat_tree
    import bsat_pkg::*;
#(
    parameter int N_IN    = 4,
    parameter int SLICE_W = 3,
    parameter int SLICES  = 3
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      in_valid,
    input  logic [N_IN*SLICE_W*SLICES-1:0]            in_data,
    output logic                                      out_valid,
    output logic [SLICE_W*SLICES+$clog2(N_IN)-1:0]    sum_out
);
    localparam int LEVELS = $clog2(N_IN);
    localparam int OP_W   = SLICE_W * SLICES;
    localparam int RES_W  = OP_W + LEVELS;
    localparam int LAT    = pipe_latency(N_IN, SLICES);
    localparam int CNT_W  = $clog2(LAT + 2) + 1;
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

    // Heap layout: node j has children 2j+1 and 2j+2, leaves at N_IN-1 and up.
    wire [RES_W-1:0] tree_w [2*N_IN-1];

    generate
        for (genvar op = 0; op < N_IN; op++) begin : g_leaf
            bsat_skew #(.SLICE_W(SLICE_W), .SLICES(SLICES), .EXT_W(LEVELS)) u_skew (
                .clk       (clk),
                .rst       (rst),
                .op_in     (in_data[op*OP_W +: OP_W]),
                .op_skewed (tree_w[N_IN-1+op])
            );
        end

        for (genvar j = 0; j < N_IN - 1; j++) begin : g_node
            bsat_node #(.SLICE_W(SLICE_W), .SLICES(SLICES), .EXT_W(LEVELS)) u_add (
                .clk   (clk),
                .rst   (rst),
                .opa   (tree_w[2*j+1]),
                .opb   (tree_w[2*j+2]),
                .sum_q (tree_w[j])
            );
        end
    endgenerate

    bsat_deskew #(.SLICE_W(SLICE_W), .SLICES(SLICES), .EXT_W(LEVELS)) u_align (
        .clk         (clk),
        .rst         (rst),
        .skewed_in   (tree_w[0]),
        .aligned_out (sum_out)
    );

    bsat_delay #(.WIDTH(1), .DEPTH(LAT)) u_vld (
        .clk (clk),
        .rst (rst),
        .d   (in_valid),
        .q   (out_valid)
    );

    // Checker state: cycles since reset, sets in flight, run of zero inputs.
    logic [CNT_W-1:0] since_rst_q;
    logic [CNT_W-1:0] inflight_q;
    logic [CNT_W-1:0] zero_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst_q <= '0;
            inflight_q  <= '0;
            zero_run_q  <= LAT_C;
        end else begin
            if (since_rst_q < LAT_C) since_rst_q <= since_rst_q + 1'b1;
            inflight_q <= inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
            if (in_data != '0)         zero_run_q <= '0;
            else if (zero_run_q < LAT_C) zero_run_q <= zero_run_q + 1'b1;
        end
    end

    assert_quiet_start_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q < LAT_C) |-> !out_valid)
        else $error("out_valid raised before pipeline filled");

    assert_inflight_bound_R4: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= LAT_C)
        else $error("more valid sets in flight than pipeline depth");

    assert_valid_source_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight_q != '0))
        else $error("out_valid without a matching input");

    assert_zero_flush_R8: assert property (@(posedge clk) disable iff (rst)
        (zero_run_q >= LAT_C) |-> (sum_out == '0))
        else $error("stale slice data after zero inputs");
endmodule

// File: tb/bsat_tree_tb.sv
`timescale 1ns/1ps
module bsat_tree_tb;
    localparam int N_OPS = 4;
    localparam int SW    = 3;
    localparam int NSL   = 3;
    localparam int OPW   = SW * NSL;
    localparam int RESW  = OPW + $clog2(N_OPS);
    localparam int LAT   = $clog2(N_OPS) + NSL - 1;
    localparam int NV    = 11;
    localparam int NG    = 16;

    typedef struct packed {
        logic [N_OPS-1:0][OPW-1:0] ops;
        logic [RESW-1:0]           total;
    } vec_t;

    // ops are listed operand 3 first, operand 0 last
    localparam vec_t VECS [NV] = '{
        '{ops: '{9'd4,   9'd3,   9'd2,   9'd1  }, total: 11'd10  },  // R1 basic
        '{ops: '{9'd511, 9'd511, 9'd511, 9'd511}, total: 11'd2044},  // R1 R8 max
        '{ops: '{9'd0,   9'd0,   9'd0,   9'd0  }, total: 11'd0   },  // R8 zero
        '{ops: '{9'd511, 9'd511, 9'd511, 9'd511}, total: 11'd2044},  // R8 max again
        '{ops: '{9'd0,   9'd0,   9'd1,   9'd511}, total: 11'd512 },  // R6 full ripple
        '{ops: '{9'd0,   9'd0,   9'd1,   9'd7  }, total: 11'd8   },  // R6 one boundary
        '{ops: '{9'd0,   9'd0,   9'd1,   9'd63 }, total: 11'd64  },  // R6 two boundaries
        '{ops: '{9'd170, 9'd341, 9'd170, 9'd341}, total: 11'd1022},  // R8 alternating bits
        '{ops: '{9'd400, 9'd300, 9'd200, 9'd100}, total: 11'd1000},  // R1 mixed
        '{ops: '{9'd5,   9'd0,   9'd0,   9'd0  }, total: 11'd5   },  // R7 top position
        '{ops: '{9'd0,   9'd0,   9'd0,   9'd258}, total: 11'd258 }   // R7 bottom position
    };

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic [N_OPS*OPW-1:0]  in_data = '0;
    logic                  out_valid;
    logic [RESW-1:0]       sum_out;

    int n_checks = 0;
    int n_fail   = 0;

    logic [NG-1:0]             gap_pat = 16'b1011_0011_1010_0110;
    logic [RESW-1:0]           gap_exp [NG];
    logic [N_OPS-1:0][OPW-1:0] g_ops;

    bsat_tree #(.N_IN(N_OPS), .SLICE_W(SW), .SLICES(NSL)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .sum_out   (sum_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [RESW-1:0] ref_sum(input logic [N_OPS-1:0][OPW-1:0] ops);
        logic [RESW-1:0] acc = '0;
        for (int k = 0; k < N_OPS; k++) acc += RESW'(ops[k]);
        return acc;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R5 reset out_valid", out_valid, 0);
        chk("R5 reset sum_out", sum_out, 0);
        rst = 1'b0;

        // Table walk, back to back: R1 R2 R3 R6 R7 R8
        for (int c = 0; c < NV + LAT; c++) begin
            if (c >= LAT) begin
                chk($sformatf("R3 vec %0d out_valid", c - LAT), out_valid, 1);
                chk($sformatf("R1 R6 R7 R8 vec %0d sum", c - LAT), sum_out, VECS[c-LAT].total);
                chk($sformatf("R1 vec %0d reference", c - LAT), sum_out, ref_sum(VECS[c-LAT].ops));
            end else begin
                chk("R2 out_valid before latency", out_valid, 0);
            end
            if (c < NV) begin
                in_valid = 1'b1;
                in_data  = VECS[c].ops;
            end else begin
                in_valid = 1'b0;
                in_data  = '0;
            end
            @(negedge clk);
        end

        // Valid pattern with gaps: R4, sum path every cycle: R3
        for (int c = 0; c < NG + LAT; c++) begin
            if (c >= LAT) begin
                chk("R4 gap out_valid", out_valid, gap_pat[c-LAT]);
                chk("R3 gap sum", sum_out, gap_exp[c-LAT]);
            end else begin
                chk("R4 gap idle out_valid", out_valid, 0);
            end
            if (c < NG) begin
                for (int k = 0; k < N_OPS; k++)
                    g_ops[k] = OPW'((c * 37 + k * 113 + 5) % 512);
                gap_exp[c] = ref_sum(g_ops);
                in_data  = g_ops;
                in_valid = gap_pat[c];
            end else begin
                in_data  = '0;
                in_valid = 1'b0;
            end
            @(negedge clk);
        end

        // Reset in mid-stream: R5
        in_valid = 1'b1;
        in_data  = '1;
        repeat (LAT + 1) @(negedge clk);
        chk("R1 all-max stream sum", sum_out, 2044);
        rst = 1'b1;
        @(negedge clk);
        chk("R5 mid-stream reset out_valid", out_valid, 0);
        chk("R5 mid-stream reset sum_out", sum_out, 0);
        rst      = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        for (int c = 0; c < LAT; c++) begin
            @(negedge clk);
            chk("R5 post-reset out_valid", out_valid, 0);
            chk("R5 post-reset sum_out", sum_out, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule